// File: doc/BRIEF.md
# Two-Channel Serial Controller Host Register Front End

This block is the processor-facing side of a two-channel serial controller. A host reaches it over a narrow bus: one address bit selects channel A or B and another selects the data register or the control space. Control registers are not addressed directly. A write to control register 0 loads a shared register pointer, and the next control access of either direction lands on the register that pointer names. After that access the pointer falls back to 0.

Most control registers exist once per channel. The interrupt vector and the master interrupt control are single copies, reached through either channel. Each channel watches its carrier-detect input. When that input changes level and the channel's external/status mask allows it, the channel latches a pending external/status event. That event can raise the single interrupt output. When the host reads the vector back through channel A, a three-bit code in the returned value names the requesting channel. The mode register of each channel is only stored and presented to the serial engine that sits downstream.

Top module: `dual_serial_regif`

## Requirements
- R1: The pointer is 0 after reset. A control write made while the pointer is 0 loads pointer bits [2:0] from write data bits [2:0]. Any other control read or write returns the pointer to 0, so the access after a targeted one reaches register 0.
- R2: In a control write made while the pointer is 0, a value of 1 in write data bits [5:3] also sets pointer bit 3, so registers 8 to 15 can be reached.
- R3: Address bit 1 = 1 selects a data access and address bit 0 selects the channel (0 = A, 1 = B). A data write stores the byte in that channel's data register and a data read returns it. Data accesses leave the pointer unchanged.
- R4: Control register 2 (vector) and control register 9 (master control) are shared, and a write through either channel updates the single copy.
- R5: When a channel's synchronised carrier-detect level changes while bit 3 of its register 15 is set, its external/status event becomes pending and stays pending until it is cleared. Its read register 15 then returns 0x08. With the mask bit clear, a level change leaves read register 15 at 0x00.
- R6: irq_out is 1 exactly when master control bit 3 is set and some channel has register 1 bit 0 set and an external/status event pending.
- R7: A register-0 write to a channel with bits [5:3] = 2 clears that channel's pending event, and its read register 15 returns to 0x00.
- R8: Read register 0 returns the channel's carrier-detect level, after two synchronising clocks, in bit 3, with every other bit 0.
- R9: Reading register 2 through channel A returns the stored vector with a code inserted: 1 for a channel A request and 5 for a channel B request, with A taking precedence. The code sits in bits [3:1], or in bits [6:4] when master control bit 4 is set.
- R10: With no channel requesting, register 2 read through channel A returns the stored vector unchanged. Register 2 read through channel B returns 0, and any control register other than 0, 2 and 15 reads as 0.
- R11: Synchronous active-low reset clears the pointer, vector, master control, masks, mode and data registers and pending events, and drives irq_out low.
- R12: A write to control register 4 of a channel appears unchanged on that channel's mode output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 2 | Bit 1: data (1) or control (0); bit 0: channel B (1) or A (0) |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during the read cycle |
| dcd_in | input | 2 | Carrier-detect level, bit 0 channel A, bit 1 channel B |
| irq_out | output | 1 | Interrupt request |
| mode_a | output | 8 | Stored mode register of channel A |
| mode_b | output | 8 | Stored mode register of channel B |

## Verification
The hardest state to reach is a channel request whose code is inserted into the vector. Getting there takes an ordered series of pointer writes to four registers across both channels, followed by a carrier-detect edge that must first pass the synchroniser. The bench walks every combination of the mask bit, the enable bit, master enable, code position and source channel. Each combination starts from reset, and after the edge has settled the bench reads the vector, the status and the interrupt output. A separate case makes both channels pending and then clears channel A, to show the precedence and the handover of the code from A to B.

// File: rtl/serreg_pkg.sv
// Package: shared constants of the dual-channel serial register front end.
// Assumes an 8-bit host bus and a 16-entry control register space.
package serreg_pkg;
    localparam int DATA_W      = 8;
    localparam int NUM_CH      = 2;
    localparam int REG_COUNT   = 16;
    localparam int PTR_W       = $clog2(REG_COUNT);
    localparam int CMD_W       = 3;
    localparam int SYNC_STAGES = 2;

    // Control register indices that the block decodes
    localparam logic [PTR_W-1:0] REG_CMD  = 4'd0;
    localparam logic [PTR_W-1:0] REG_IE   = 4'd1;
    localparam logic [PTR_W-1:0] REG_VEC  = 4'd2;
    localparam logic [PTR_W-1:0] REG_MODE = 4'd4;
    localparam logic [PTR_W-1:0] REG_MIC  = 4'd9;
    localparam logic [PTR_W-1:0] REG_EXT  = 4'd15;

    // Command field codes carried in bits [5:3] of a register-0 write
    localparam logic [CMD_W-1:0] CMD_POINT_HI = 3'd1;
    localparam logic [CMD_W-1:0] CMD_CLR_EXT  = 3'd2;

    // Bit positions
    localparam int EXT_DCD_BIT = 3;
    localparam int IE_EXT_BIT  = 0;
    localparam int MIC_MIE_BIT = 3;
    localparam int MIC_HI_BIT  = 4;

    // Source codes placed into the vector
    localparam logic [2:0] SRC_CODE_A = 3'd1;
    localparam logic [2:0] SRC_CODE_B = 3'd5;
endpackage

// File: rtl/serreg_ptr.sv
// Module: serreg_ptr
// Holds the shared control register pointer. A control write made while the
// pointer is 0 loads it; any other control access returns it to 0.
// Assumes the caller never raises ctrl_wr and ctrl_rd together.
module serreg_ptr
    import serreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             ctrl_rd,
    input  logic [5:0]       wdata_lo,
    output logic [PTR_W-1:0] ptr_q
);
    logic             load_now;
    logic [PTR_W-1:0] load_val;

    // Work out whether this cycle loads a new pointer and what value it takes
    always_comb begin
        load_now = ctrl_wr && (ptr_q == REG_CMD);
        load_val = {wdata_lo[5:3] == CMD_POINT_HI, wdata_lo[2:0]};
    end

    // Pointer register: load, or fall back to zero after a targeted access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load_now) begin
            ptr_q <= load_val;
        end else if (ctrl_wr || ctrl_rd) begin
            ptr_q <= '0;
        end
    end

    assert_ptr_return_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_wr || ctrl_rd) && ptr_q != '0) |=> (ptr_q == '0));

    assert_point_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ptr_q == '0 && wdata_lo[5:3] == CMD_POINT_HI) |=> ptr_q[PTR_W-1]);
endmodule

// File: rtl/serreg_chan.sv
// Module: serreg_chan
// One channel's private registers: data, interrupt enable, mode and
// external/status mask. It also holds the carrier-detect synchroniser and the
// pending event latch. Assumes the carrier-detect input is low during reset.
module serreg_chan
    import serreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dcd_in,
    input  logic              data_we,
    input  logic              ctrl_we,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] data_q,
    output logic [DATA_W-1:0] mode_q,
    output logic [DATA_W-1:0] rr0,
    output logic [DATA_W-1:0] rr15,
    output logic              irq_req
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   dcd_lvl;
    logic                   dcd_prev_q;
    logic                   dcd_change;
    logic                   ie_ext_q;
    logic                   mask_dcd_q;
    logic                   pend_q;
    logic                   clr_ext;
    logic                   set_ext;

    // Carrier-detect synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], dcd_in};
        end
    end

    // Previous synchronised level, kept for change detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dcd_prev_q <= 1'b0;
        end else begin
            dcd_prev_q <= dcd_lvl;
        end
    end

    // Decode level change, event set and command clear
    always_comb begin
        dcd_lvl    = sync_q[SYNC_STAGES-1];
        dcd_change = dcd_lvl ^ dcd_prev_q;
        set_ext    = dcd_change && mask_dcd_q;
        clr_ext    = ctrl_we && (ptr == REG_CMD) && (wdata[5:3] == CMD_CLR_EXT);
    end

    // Private control registers written through the pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_ext_q   <= 1'b0;
            mask_dcd_q <= 1'b0;
            mode_q     <= '0;
        end else if (ctrl_we) begin
            if (ptr == REG_IE)   ie_ext_q   <= wdata[IE_EXT_BIT];
            if (ptr == REG_EXT)  mask_dcd_q <= wdata[EXT_DCD_BIT];
            if (ptr == REG_MODE) mode_q     <= wdata;
        end
    end

    // Data register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (data_we) begin
            data_q <= wdata;
        end
    end

    // Pending external/status event; a new event wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (set_ext) begin
            pend_q <= 1'b1;
        end else if (clr_ext) begin
            pend_q <= 1'b0;
        end
    end

    // Read-back images and the request to the interrupt logic
    always_comb begin
        rr0                 = '0;
        rr0[EXT_DCD_BIT]    = dcd_lvl;
        rr15                = '0;
        rr15[EXT_DCD_BIT]   = pend_q;
        irq_req             = ie_ext_q && pend_q;
    end

    assert_rise_needs_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(mask_dcd_q));

    assert_pending_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !clr_ext) |=> pend_q);

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ext && !set_ext) |=> !pend_q);
endmodule

// File: rtl/serreg_vec.sv
// Module: serreg_vec
// Shared vector and master interrupt control registers. Builds the
// read-back vector with the source code inserted and drives the interrupt
// output. Assumes req[0] is channel A and req[1] is channel B.
module serreg_vec
    import serreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NUM_CH-1:0] req,
    output logic [DATA_W-1:0] vec_rd,
    output logic              irq_out
);
    logic [DATA_W-1:0] vec_q;
    logic              mie_q;
    logic              hi_q;
    logic [2:0]        code;

    // Shared registers, written through whichever channel was addressed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
            mie_q <= 1'b0;
            hi_q  <= 1'b0;
        end else if (ctrl_we) begin
            if (ptr == REG_VEC) vec_q <= wdata;
            if (ptr == REG_MIC) begin
                mie_q <= wdata[MIC_MIE_BIT];
                hi_q  <= wdata[MIC_HI_BIT];
            end
        end
    end

    // Pick the source code with channel A first and merge it into the vector
    always_comb begin
        code   = req[0] ? SRC_CODE_A : SRC_CODE_B;
        vec_rd = vec_q;
        if (|req) begin
            if (hi_q) vec_rd[6:4] = code;
            else      vec_rd[3:1] = code;
        end
        irq_out = mie_q && (|req);
    end

    assert_irq_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (req != '0));
endmodule

// File: rtl/dual_serial_regif.sv
// Module: dual_serial_regif
// Host register front end of a two-channel serial controller: it decodes
// the address, holds the shared pointer, one register set per channel and
// the shared interrupt registers, and muxes read data. Assumes one access
// per strobe cycle; read data is combinational in the read cycle.
module dual_serial_regif
    import serreg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic [1:0]  dcd_in,
    output logic        irq_out,
    output logic [7:0]  mode_a,
    output logic [7:0]  mode_b
);
    logic              is_data;
    logic              ch_sel;
    logic              ctrl_wr;
    logic              ctrl_rd;
    logic [PTR_W-1:0]  ptr_q;
    logic [NUM_CH-1:0] req;
    logic [DATA_W-1:0] vec_rd;
    logic [DATA_W-1:0] data_q [NUM_CH];
    logic [DATA_W-1:0] mode_q [NUM_CH];
    logic [DATA_W-1:0] rr0    [NUM_CH];
    logic [DATA_W-1:0] rr15   [NUM_CH];

    // Address decode into control and data strobes
    always_comb begin
        is_data = bus_addr[1];
        ch_sel  = bus_addr[0];
        ctrl_wr = bus_wr && !is_data;
        ctrl_rd = bus_rd && !bus_wr && !is_data;
    end

    serreg_ptr u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .ctrl_rd  (ctrl_rd),
        .wdata_lo (bus_wdata[5:0]),
        .ptr_q    (ptr_q)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        serreg_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .dcd_in  (dcd_in[ch]),
            .data_we (bus_wr && is_data && (ch_sel == ch[0])),
            .ctrl_we (ctrl_wr && (ch_sel == ch[0])),
            .ptr     (ptr_q),
            .wdata   (bus_wdata),
            .data_q  (data_q[ch]),
            .mode_q  (mode_q[ch]),
            .rr0     (rr0[ch]),
            .rr15    (rr15[ch]),
            .irq_req (req[ch])
        );
    end

    serreg_vec u_vec (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_we (ctrl_wr),
        .ptr     (ptr_q),
        .wdata   (bus_wdata),
        .req     (req),
        .vec_rd  (vec_rd),
        .irq_out (irq_out)
    );

    // Read mux: data register, or the control register the pointer names
    always_comb begin
        bus_rdata = '0;
        if (is_data) begin
            bus_rdata = data_q[ch_sel];
        end else begin
            case (ptr_q)
                REG_CMD: bus_rdata = rr0[ch_sel];
                REG_VEC: bus_rdata = ch_sel ? '0 : vec_rd;
                REG_EXT: bus_rdata = rr15[ch_sel];
                default: bus_rdata = '0;
            endcase
        end
    end

    // Mode registers out to the serial engine
    always_comb begin
        mode_a = mode_q[0];
        mode_b = mode_q[1];
    end

    assert_irq_has_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (rr15[0][EXT_DCD_BIT] || rr15[1][EXT_DCD_BIT]));

    assert_data_keeps_ptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && is_data) |=> $stable(ptr_q));
endmodule

// File: tb/sim_dual_serial_regif.sv
module sim_dual_serial_regif;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'b00;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [1:0] dcd_in = 2'b00;
    logic       irq_out;
    logic [7:0] mode_a, mode_b;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] rbuf;

    always #2.5 clk = ~clk;

    dual_serial_regif u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dcd_in(dcd_in), .irq_out(irq_out), .mode_a(mode_a), .mode_b(mode_b)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic bus(input logic [1:0] a, input logic w, input logic r, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
        #1 rbuf = bus_rdata;
        @(posedge clk);
        #0.5 bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic point(input logic ch, input int r);
        logic [7:0] v;
        v = {2'b00, (r >= 8) ? 3'd1 : 3'd0, 3'(r % 8)};
        bus({1'b0, ch}, 1'b1, 1'b0, v);
    endtask

    task automatic wr_reg(input logic ch, input int r, input logic [7:0] v);
        if (r != 0) point(ch, r);
        bus({1'b0, ch}, 1'b1, 1'b0, v);
    endtask

    task automatic rd_reg(input logic ch, input int r, output logic [7:0] v);
        if (r != 0) point(ch, r);
        bus({1'b0, ch}, 1'b0, 1'b1, 8'h00);
        v = rbuf;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; dcd_in = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] ins(input logic [7:0] v, input logic [2:0] c, input bit hi);
        int sh;
        sh = hi ? 4 : 1;
        return (v & ~(8'h07 << sh)) | (8'(c) << sh);
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        do_reset();
        // R11: reset state
        #1;
        check("R11 irq", {7'b0, irq_out}, 8'h00);
        check("R11 mode_a", mode_a, 8'h00);
        check("R11 mode_b", mode_b, 8'h00);
        rd_reg(1'b0, 0, v); check("R11 rr0", v, 8'h00);
        rd_reg(1'b0, 2, v); check("R11 vector", v, 8'h00);
        rd_reg(1'b1, 15, v); check("R11 rr15", v, 8'h00);
        bus(2'b10, 1'b0, 1'b1, 8'h00); check("R11 data", rbuf, 8'h00);

        // R1 R2 R4 R8 R10: pointer sweep over all registers on both channels
        dcd_in = 2'b01;
        wait_cyc(4);
        wr_reg(1'b1, 2, 8'h3C);          // shared vector written via B (R4)
        for (int ch = 0; ch < 2; ch++) begin
            for (int r = 0; r < 16; r++) begin
                logic [7:0] e;
                rd_reg(1'(ch), r, v);
                if (r == 0)      e = (ch == 0) ? 8'h08 : 8'h00;
                else if (r == 2) e = (ch == 0) ? 8'h3C : 8'h00;
                else             e = 8'h00;
                check("R1 R2 R8 R10 sweep", v, e);
                // R1: the pointer went back to 0, so a plain read hits register 0
                bus({1'b0, 1'(ch)}, 1'b0, 1'b1, 8'h00);
                check("R1 return to 0", rbuf, (ch == 0) ? 8'h08 : 8'h00);
            end
        end

        // R3: data registers per channel, pointer untouched by data access
        for (int k = 0; k < 8; k++) begin
            logic [7:0] da, db;
            da = 8'(k * 37 + 5); db = ~da;
            bus(2'b10, 1'b1, 1'b0, da);
            bus(2'b11, 1'b1, 1'b0, db);
            bus(2'b10, 1'b0, 1'b1, 8'h00); check("R3 data A", rbuf, da);
            bus(2'b11, 1'b0, 1'b1, 8'h00); check("R3 data B", rbuf, db);
        end
        point(1'b0, 2);
        bus(2'b11, 1'b1, 1'b0, 8'h99);
        bus(2'b10, 1'b0, 1'b1, 8'h00);
        bus(2'b00, 1'b0, 1'b1, 8'h00);
        check("R3 pointer kept", rbuf, 8'h3C);

        // R12: mode registers
        wr_reg(1'b0, 4, 8'hA7);
        wr_reg(1'b1, 4, 8'h5C);
        #1;
        check("R12 mode_a", mode_a, 8'hA7);
        check("R12 mode_b", mode_b, 8'h5C);

        // R5 R6 R7 R9 R10 R4: every mask/enable/master/position/channel combo
        for (int m = 0; m < 32; m++) begin
            bit mk, ie, mie, hi, ch;
            logic [7:0] vec, ev;
            mk = m[0]; ie = m[1]; mie = m[2]; hi = m[3]; ch = m[4];
            vec = 8'h96 ^ 8'(m);
            do_reset();
            wr_reg(ch, 15, mk ? 8'h08 : 8'h00);
            wr_reg(ch, 1, ie ? 8'h01 : 8'h00);
            wr_reg(ch, 9, {3'b000, hi, mie, 3'b000});   // R4 shared via either channel
            wr_reg(1'b0, 2, vec);
            dcd_in[ch] = 1'b1;
            wait_cyc(6);
            check("R6 irq", {7'b0, irq_out}, {7'b0, mk & ie & mie});
            rd_reg(ch, 15, v); check("R5 rr15", v, mk ? 8'h08 : 8'h00);
            rd_reg(ch, 0, v);  check("R8 rr0", v, 8'h08);
            ev = (mk & ie) ? ins(vec, ch ? 3'd5 : 3'd1, hi) : vec;
            rd_reg(1'b0, 2, v); check("R9 R10 vector", v, ev);
            wr_reg(ch, 0, 8'h10);                        // command 2
            wait_cyc(1);
            check("R7 irq cleared", {7'b0, irq_out}, 8'h00);
            rd_reg(ch, 15, v); check("R7 rr15 cleared", v, 8'h00);
        end

        // R9: both channels pending, A first, then B after A is cleared
        do_reset();
        for (int ch = 0; ch < 2; ch++) begin
            wr_reg(1'(ch), 15, 8'h08);
            wr_reg(1'(ch), 1, 8'h01);
        end
        wr_reg(1'b0, 9, 8'h08);
        wr_reg(1'b0, 2, 8'h00);
        dcd_in = 2'b11;
        wait_cyc(6);
        rd_reg(1'b0, 2, v); check("R9 priority A", v, 8'h02);
        rd_reg(1'b1, 2, v); check("R10 vector via B", v, 8'h00);
        wr_reg(1'b0, 0, 8'h10);
        rd_reg(1'b0, 2, v); check("R9 code B", v, 8'h0A);
        check("R6 irq B only", {7'b0, irq_out}, 8'h01);
        // R5: pending stays set with no further edge
        wait_cyc(10);
        rd_reg(1'b1, 15, v); check("R5 sticky", v, 8'h08);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule